// File: doc/BRIEF.md
# Serial Inverse Walsh Transform

This block turns a set of N signed Walsh coefficients, handed over all at once, back into N time-domain samples. The samples leave one per clock. A load strobe latches the coefficient vector into N holding registers and starts a sample counter at index 0.

For each index t, every coefficient n is either added as it is or negated. The rule is the parity of the bitwise AND of n and t. The signed terms are summed by a balanced tree of N-1 adders, and the sum is scaled by 1/N with an arithmetic right shift. The result is registered onto the sample output together with a valid flag.

When the coefficients are the unscaled forward Walsh transform of a frame, the block returns that frame exactly. After N samples the block goes idle until the next load.

Top module: `walsh_inverse_serial`

## Requirements
- R1: While reset is held and before the first load, `valid_o` is 0 and `sample_o` is 0.
- R2: A load latches `coef_i`, where coefficient n occupies bits [n*COEF_W +: COEF_W] in two's complement. In the cycle after the load edge `valid_o` is 0. Sample 0 appears with `valid_o`=1 one edge later.
- R3: After a load that is not interrupted, exactly N samples with `valid_o`=1 appear on consecutive cycles, in index order 0..N-1. After that `valid_o` returns to 0.
- R4: Sample t equals the low SAMP_W bits of floor(S/N). Here S is the sum over n of c_n, with c_n negated when the number of set bits in (n AND t) is odd.
- R5: Coefficient 0 always enters the sum with a positive sign, whatever the index.
- R6: The scaling by 1/N rounds toward minus infinity for sums that are not a multiple of N. For example, S=-5 with N=4 gives -2.
- R7: Loading the unscaled forward transform A_n = sum_t s(n,t)*x_t of any SAMP_W-bit frame x reproduces x exactly, sample by sample.
- R8: A load during an output sequence abandons it. The next cycle shows `valid_o`=0, and then the new frame is output from index 0.
- R9: While idle and without a load, `valid_o` stays 0 and `sample_o` holds its last value, even when `coef_i` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Latch the coefficient vector and start a new output sequence |
| coef_i | input | N_PTS*COEF_W | Signed coefficients, coefficient n in slice n |
| valid_o | output | 1 | Sample output is a new valid sample |
| sample_o | output | SAMP_W | Reconstructed signed sample |

## Verification
The assertions assume that `load_i` is a clean synchronous level and that N_PTS is a power of two. They make no assumption about the spacing of loads, so the restart property must hold under any load pattern. The stimulus drives `load_i` and `coef_i` only at falling edges and holds the load for one cycle. It issues loads both while idle and in the middle of a sequence, and it scrambles `coef_i` while no load is present. The checks cover coefficient values over the full signed range, including the most negative code, whose negation needs one extra bit.

// File: rtl/walsh_inv_pkg.sv
package walsh_inv_pkg;
  // odd parity of (coef index AND sample index) => subtract the coefficient
  function automatic logic walsh_neg(input int unsigned n, input int unsigned t);
    return ^(n & t);
  endfunction
endpackage

// File: rtl/walsh_sign_gen.sv
module walsh_sign_gen #(
  parameter int unsigned N_PTS = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [N_PTS-2:0] neg_o   // bit n-1 belongs to coefficient n
);
  for (genvar n = 1; n < N_PTS; n++) begin : g_sign
    assign neg_o[n-1] = ^(idx_i & IDX_W'(n));
  end
endmodule

// File: rtl/walsh_term_sel.sv
module walsh_term_sel #(
  parameter int unsigned COEF_W = 6,
  parameter int unsigned TERM_W = COEF_W + 1
) (
  input  logic [COEF_W-1:0] coef_i,
  input  logic              neg_i,
  output logic [TERM_W-1:0] term_o
);
  logic signed [TERM_W-1:0] ext;
  assign ext    = TERM_W'(signed'(coef_i));
  assign term_o = neg_i ? -ext : ext;
endmodule

// File: rtl/walsh_adder_tree.sv
module walsh_adder_tree #(
  parameter int unsigned N_PTS = 4,
  parameter int unsigned IN_W  = 7,
  parameter int unsigned OUT_W = 9
) (
  input  logic [N_PTS-1:0][IN_W-1:0] term_i,
  output logic [OUT_W-1:0]           sum_o
);
  // heap layout: nodes 0..N-2 are adders, N-1..2N-2 are leaves
  logic signed [OUT_W-1:0] node [2*N_PTS-1];

  for (genvar i = 0; i < N_PTS; i++) begin : g_leaf
    assign node[N_PTS-1+i] = OUT_W'(signed'(term_i[i]));
  end
  for (genvar i = 0; i < N_PTS - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end
  assign sum_o = node[0];
endmodule

// File: rtl/walsh_inverse_serial.sv
module walsh_inverse_serial #(
  parameter int unsigned N_PTS  = 4,
  parameter int unsigned COEF_W = 6,
  parameter int unsigned SAMP_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [N_PTS*COEF_W-1:0] coef_i,
  output logic                    valid_o,
  output logic [SAMP_W-1:0]       sample_o
);
  localparam int unsigned LOG_N  = $clog2(N_PTS);
  localparam int unsigned IDX_W  = (LOG_N > 0) ? LOG_N : 1;
  localparam int unsigned TERM_W = COEF_W + 1;
  localparam int unsigned SUM_W  = TERM_W + LOG_N;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_PTS - 1);

  logic [N_PTS-1:0][COEF_W-1:0] coef_q;
  logic [IDX_W-1:0]             idx_q;
  logic                         busy_q;
  logic [N_PTS-2:0]             neg;
  logic [N_PTS-1:0][TERM_W-1:0] term;
  logic [SUM_W-1:0]             sum;
  logic [SAMP_W-1:0]            sample_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      coef_q <= coef_i;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      idx_q <= idx_q + IDX_W'(1);
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
    end
  end

  walsh_sign_gen #(.N_PTS(N_PTS), .IDX_W(IDX_W)) i_sign (
    .idx_i (idx_q),
    .neg_o (neg)
  );

  // coefficient 0 carries the all-ones Walsh row: never negated
  assign term[0] = TERM_W'(signed'(coef_q[0]));
  for (genvar n = 1; n < N_PTS; n++) begin : g_term
    walsh_term_sel #(.COEF_W(COEF_W), .TERM_W(TERM_W)) i_sel (
      .coef_i (coef_q[n]),
      .neg_i  (neg[n-1]),
      .term_o (term[n])
    );
  end

  walsh_adder_tree #(.N_PTS(N_PTS), .IN_W(TERM_W), .OUT_W(SUM_W)) i_tree (
    .term_i (term),
    .sum_o  (sum)
  );

  // divide by N: arithmetic shift floors toward minus infinity
  assign sample_d = SAMP_W'(signed'(sum) >>> LOG_N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else if (load_i) begin
      valid_o <= 1'b0;
    end else if (busy_q) begin
      valid_o  <= 1'b1;
      sample_o <= sample_d;
    end else begin
      valid_o <= 1'b0;
    end
  end

  assert_load_starts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (busy_q && idx_q == '0 && !valid_o));
  assert_run_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !load_i) |=> valid_o);
  assert_index_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !load_i && idx_q != LAST_IDX) |=> (busy_q && idx_q == $past(idx_q) + IDX_W'(1)));
  assert_run_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !load_i && idx_q == LAST_IDX) |=> !busy_q);
  assert_restart_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && busy_q) |=> !valid_o);
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !load_i) |=> (!valid_o && $stable(sample_o)));
endmodule

// File: tb/test_walsh_inverse_serial.sv
module test_walsh_inverse_serial;
  localparam int N = 4;
  localparam int CW = 6;
  localparam int SW = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [N*CW-1:0] coef = '0;
  logic valid;
  logic [SW-1:0] sample;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  walsh_inverse_serial #(.N_PTS(N), .COEF_W(CW), .SAMP_W(SW)) i_walsh_inverse_serial (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .coef_i(coef),
    .valid_o(valid), .sample_o(sample)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sgn(input int n, input int t);
    int p = 0;
    for (int b = 0; b < 8; b++) p ^= ((n & t) >> b) & 1;
    return p ? -1 : 1;
  endfunction

  function automatic int floor_div(input int s);
    if (s >= 0) return s / N;
    return -((-s + N - 1) / N);
  endfunction

  function automatic int expect_samp(input int c[N], input int t);
    int s = 0;
    for (int n = 0; n < N; n++) s += sgn(n, t) * c[n];
    return floor_div(s) & ((1 << SW) - 1);
  endfunction

  function automatic logic [N*CW-1:0] pack(input int c[N]);
    logic [N*CW-1:0] v = '0;
    for (int n = 0; n < N; n++) v[n*CW +: CW] = CW'(c[n]);
    return v;
  endfunction

  // called at a falling edge; returns at the falling edge after the load edge
  task automatic start_load(input int c[N]);
    load = 1'b1;
    coef = pack(c);
    @(negedge clk);
    load = 1'b0;
    coef = ~coef;  // scramble: must be ignored without a load
  endtask

  task automatic check_frame(input int c[N], input string req);
    chk(valid == 1'b0, "R2 gap after load", valid, 0);
    for (int t = 0; t < N; t++) begin
      @(negedge clk);
      chk(valid == 1'b1, "R3 valid run", valid, 1);
      chk(int'(sample) == expect_samp(c, t), req, sample, expect_samp(c, t));
    end
    @(negedge clk);
    chk(valid == 1'b0, "R3 idle after N", valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c[N];
    int x[N];
    int vals[5] = '{-8, -3, 0, 5, 7};
    int seed = 12345;
    logic [SW-1:0] held;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(valid == 1'b0 && sample == '0, "R1 reset", sample, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0 && sample == '0, "R1 idle after reset", sample, 0);

    // R5 only coefficient 0 set: constant output
    c = '{20, 0, 0, 0};
    start_load(c); check_frame(c, "R5 coef0 positive");
    c = '{-32, 0, 0, 0};
    start_load(c); check_frame(c, "R5 coef0 most negative");

    // R6 floor on non-multiples of N
    c = '{-5, 0, 0, 0};
    start_load(c); check_frame(c, "R6 floor -5");
    c = '{1, -2, 3, -6};
    start_load(c); check_frame(c, "R6 floor mixed");

    // R4 extreme codes, including negation of the most negative value
    c = '{-32, -32, -32, -32};
    start_load(c); check_frame(c, "R4 all min");
    c = '{31, -32, 31, -32};
    start_load(c); check_frame(c, "R4 alternating");

    // R4 pseudo-random coefficient vectors
    for (int k = 0; k < 400; k++) begin
      for (int n = 0; n < N; n++) begin
        seed = seed * 1103515245 + 12345;
        c[n] = ((seed >>> 16) & 63) - 32;
      end
      start_load(c); check_frame(c, "R4 random");
    end

    // R7 round trip over a grid of frames
    foreach (vals[a]) foreach (vals[b]) foreach (vals[d]) foreach (vals[e]) begin
      x = '{vals[a], vals[b], vals[d], vals[e]};
      for (int n = 0; n < N; n++) begin
        c[n] = 0;
        for (int t = 0; t < N; t++) c[n] += sgn(n, t) * x[t];
      end
      start_load(c);
      chk(valid == 1'b0, "R2 gap", valid, 0);
      for (int t = 0; t < N; t++) begin
        @(negedge clk);
        chk(valid && int'(signed'(sample)) == x[t], "R7 round trip",
            int'(signed'(sample)), x[t]);
      end
      @(negedge clk);
    end

    // R8 restart in the middle of a sequence
    c = '{8, 4, -12, 16};
    start_load(c);
    @(negedge clk);
    chk(valid && int'(sample) == expect_samp(c, 0), "R8 first frame sample0", sample, expect_samp(c, 0));
    c = '{-20, 12, 3, 9};
    start_load(c);
    check_frame(c, "R8 restarted frame");

    // R9 idle: output holds while coef_i moves
    held = sample;
    for (int k = 0; k < 6; k++) begin
      coef = pack('{k * 5 - 13, 7 - k, k, -k});
      @(negedge clk);
      chk(valid == 1'b0 && sample == held, "R9 idle hold", sample, held);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule